// File: doc/BRIEF.md
# NAND Flash Controller Register and Command Front-End

This block is the software-facing register file of a NAND flash controller that drives one chip select. A processor writes a control word (a run bit, four feature enables, geometry flags and twelve interrupt mask bits), two timing words, and a status word whose event bits are cleared by writing ones. The pin sequencing, data path, error correction and any transfer engine sit behind the block and receive its configuration as plain outputs.

A command starts when software sets the run bit. The block then posts a command-request event and accepts exactly three writes to one command-queue address, in the order word 0, word 1, word 2. Once the third word lands, it hands all three words to the downstream sequencer with a single-cycle valid pulse. It then waits for the sequencer's done pulse, posts a command-done event and drops the run bit on its own. Writing the run bit to 0 aborts a command at any point. One interrupt line is driven from the unmasked status events.

Top module: `nfc_regfront`

## Requirements
- R1: After a synchronous active-low reset, the control, both timing and status registers read 0 (bit 12 of status follows its input level), `irq` and `cmd_valid` are 0 and `cmd_words` is all zeros.
- R2: Control is at offset 0x00, timing 0 at 0x04, timing 1 at 0x0C, status at 0x14 and the command queue at 0x48. Control and timing words read back as written and drive `ctl_cfg`, `tim0_cfg` and `tim1_cfg`. Any other offset (0x40 included) reads 0, and a write to it changes no register.
- R3: A control write that takes bit 28 (run) from 0 to 1 sets status bit 0 (command request) on the same clock edge and arms command loading at word 0.
- R4: While loading is armed, writes to 0x48 are captured in order as word 0, 1 and 2. The edge that captures word 2 raises `cmd_valid` for exactly one cycle, and `cmd_words` then holds word k in bits 32k+31:32k.
- R5: A write to 0x48 while loading is not armed is ignored. This covers writes before run rises and a fourth write in the same command. `cmd_words` does not change and no `cmd_valid` pulse follows.
- R6: A `seq_done` pulse, while the block waits after issuing a command, sets status bit 8 and clears the run bit on the same edge. A `seq_done` pulse at any other time has no effect.
- R7: A control write with bit 28 = 0 while run is 1 aborts the command. Partly loaded words are discarded, no command-done event is posted for it, and the next run rise starts again at word 0.
- R8: A status write clears each bit of 11:0 that is written 1 and leaves the others unchanged, so writing 0xFFF clears all events. An event arriving on the same edge as its clear leaves the bit set.
- R9: Inputs `ev_rd_req`, `ev_wr_req`, `ev_sbe`, `ev_dbe` and `ev_flash_rdy` set status bits 1, 2, 3, 4 and 11. Status bits 5, 6, 7, 9 and 10 always read 0. Bit 12 reads the `flash_rdy_lvl` input directly, and bits 31:13 read 0.
- R10: `irq` is the OR of the status bits 11:0 whose control mask bit (same position in control 11:0) is 0. It is registered, so it follows the status register and mask one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| ev_rd_req | input | 1 | Read-data request event |
| ev_wr_req | input | 1 | Write-data request event |
| ev_sbe | input | 1 | Single-bit error event |
| ev_dbe | input | 1 | Double-bit error event |
| ev_flash_rdy | input | 1 | Flash became ready event |
| flash_rdy_lvl | input | 1 | Live ready level shown in status bit 12 |
| seq_done | input | 1 | Sequencer finished the issued command |
| cmd_valid | output | 1 | One-cycle pulse: `cmd_words` holds a new command |
| cmd_words | output | 32*CMD_WORDS | Captured command words, word k in bits 32k+31:32k |
| ctl_cfg | output | 32 | Current control word |
| tim0_cfg | output | 32 | Timing word 0 |
| tim1_cfg | output | 32 | Timing word 1 |
| irq | output | 1 | Interrupt request |

## Verification
Register writes, event inputs and `seq_done` all take effect on the edge that samples them. So status, control, the captured words and `cmd_valid` are checked at the falling edge right after that edge, and `cmd_valid` is checked low again one cycle later. `irq` has one more register in its path, so each interrupt check waits one further falling edge after the status change is confirmed. The bench drives every input at a falling edge and reads `reg_rdata` shortly after, well away from the active edge. It sweeps all 32 combinations of the five event inputs against three mask patterns, with the expected status word and interrupt computed arithmetically from the bit assignments.

// File: rtl/nfc_pkg.sv
// nfc_pkg: register offsets, bit positions and loader states shared by the
// NAND command front-end. Assumes 32-bit registers and byte offsets.
package nfc_pkg;
    localparam int REG_W = 32;
    localparam int EVT_W = 12;

    localparam logic [7:0] OFS_CTL  = 8'h00;
    localparam logic [7:0] OFS_TIM0 = 8'h04;
    localparam logic [7:0] OFS_TIM1 = 8'h0C;
    localparam logic [7:0] OFS_STAT = 8'h14;
    localparam logic [7:0] OFS_CMDQ = 8'h48;

    localparam int CTL_RUN   = 28;
    localparam int CTL_DMA   = 29;
    localparam int CTL_ECC   = 30;
    localparam int CTL_SPARE = 31;

    localparam int ST_CMDREQ = 0;
    localparam int ST_RDREQ  = 1;
    localparam int ST_WRREQ  = 2;
    localparam int ST_SBE    = 3;
    localparam int ST_DBE    = 4;
    localparam int ST_DONE   = 8;
    localparam int ST_FRDY   = 11;
    localparam int ST_RDYLVL = 12;

    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_FILL = 2'd1,
        LD_WAIT = 2'd2
    } ld_state_e;
endpackage

// File: rtl/nfc_cfg_regs.sv
// nfc_cfg_regs: control and timing registers. The run bit is written by
// software and cleared by hardware when a command completes; a software write
// on the same edge takes priority. Detects run rise and software abort.
// Assumes a single write port (one register written per cycle).
module nfc_cfg_regs
    import nfc_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_ctl,
    input  logic         we_tim0,
    input  logic         we_tim1,
    input  logic [W-1:0] wdata,
    input  logic         run_clr,
    output logic [W-1:0] ctl_q,
    output logic [W-1:0] tim0_q,
    output logic [W-1:0] tim1_q,
    output logic         run_rise,
    output logic         run_abort
);

    // Edge detection of the run bit on software writes.
    always_comb begin
        run_rise  = we_ctl &&  wdata[CTL_RUN] && !ctl_q[CTL_RUN];
        run_abort = we_ctl && !wdata[CTL_RUN] &&  ctl_q[CTL_RUN];
    end

    // Control register: software write, else hardware clear of run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (we_ctl) begin
            ctl_q <= wdata;
        end else if (run_clr) begin
            ctl_q[CTL_RUN] <= 1'b0;
        end
    end

    // Timing words: plain storage handed to the pin sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim0_q <= '0;
            tim1_q <= '0;
        end else begin
            if (we_tim0) tim0_q <= wdata;
            if (we_tim1) tim1_q <= wdata;
        end
    end

endmodule

// File: rtl/nfc_cmd_loader.sv
// nfc_cmd_loader: collects WORDS consecutive writes to the command queue
// address once armed by a run rise, issues them with a one-cycle valid pulse,
// then waits for the sequencer's done pulse. Abort returns it to idle.
// Assumes start, abort and push never coincide (single write port).
module nfc_cmd_loader
    import nfc_pkg::*;
#(
    parameter int W     = REG_W,
    parameter int WORDS = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           abort,
    input  logic           push,
    input  logic [W-1:0]   wdata,
    input  logic           seq_done,
    output logic           cmd_valid,
    output logic [W*WORDS-1:0] cmd_words,
    output logic           done_evt,
    output logic           filling,
    output logic           waiting
);

    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

    ld_state_e        state;
    logic [IDX_W-1:0] idx;
    logic             take;

    // Status of the loader seen by neighbours.
    always_comb begin
        filling  = (state == LD_FILL);
        waiting  = (state == LD_WAIT);
        take     = filling && push;
        done_evt = waiting && seq_done && !abort;
    end

    // Loader sequence: idle -> fill (WORDS pushes) -> wait for done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= LD_IDLE;
            idx       <= '0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (abort) begin
                state <= LD_IDLE;
                idx   <= '0;
            end else if (start) begin
                state <= LD_FILL;
                idx   <= '0;
            end else begin
                case (state)
                    LD_FILL: begin
                        if (push) begin
                            if (idx == LAST) begin
                                state     <= LD_WAIT;
                                idx       <= '0;
                                cmd_valid <= 1'b1;
                            end else begin
                                idx <= idx + 1'b1;
                            end
                        end
                    end
                    LD_WAIT: begin
                        if (seq_done) state <= LD_IDLE;
                    end
                    default: state <= LD_IDLE;
                endcase
            end
        end
    end

    // One holding register per command word, written when its slot is next.
    for (genvar k = 0; k < WORDS; k++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmd_words[k*W +: W] <= '0;
            end else if (take && idx == IDX_W'(k)) begin
                cmd_words[k*W +: W] <= wdata;
            end
        end
    end

endmodule

// File: rtl/nfc_stat_regs.sv
// nfc_stat_regs: write-1-to-clear event register and registered interrupt.
// An event on the same edge as its clear wins. The interrupt follows the
// status and mask one cycle later.
module nfc_stat_regs
    import nfc_pkg::*;
#(
    parameter int N = EVT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         w1c_we,
    input  logic [N-1:0] w1c_bits,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] mask,
    output logic [N-1:0] stat_q,
    output logic         irq
);

    logic [N-1:0] clr_vec;

    // Clear vector only exists during a status write.
    always_comb clr_vec = w1c_we ? w1c_bits : '0;

    // Event bits: hold, clear on 1-write, set on event (set wins).
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_vec) | set_vec;
    end

    // Interrupt: one register after the unmasked events.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(stat_q & ~mask);
    end

endmodule

// File: rtl/nfc_regfront.sv
// nfc_regfront: register front-end of a single chip-select NAND controller.
// Decodes register writes, assembles status events, muxes read data and
// connects the configuration, status and command-loading submodules.
// Assumes ADDR_W >= 8 and a write port that accepts one write per cycle.
module nfc_regfront
    import nfc_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int CMD_WORDS = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_wr,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [REG_W-1:0]           reg_wdata,
    output logic [REG_W-1:0]           reg_rdata,
    input  logic                       ev_rd_req,
    input  logic                       ev_wr_req,
    input  logic                       ev_sbe,
    input  logic                       ev_dbe,
    input  logic                       ev_flash_rdy,
    input  logic                       flash_rdy_lvl,
    input  logic                       seq_done,
    output logic                       cmd_valid,
    output logic [REG_W*CMD_WORDS-1:0] cmd_words,
    output logic [REG_W-1:0]           ctl_cfg,
    output logic [REG_W-1:0]           tim0_cfg,
    output logic [REG_W-1:0]           tim1_cfg,
    output logic                       irq
);

    localparam int STAT_PAD = REG_W - EVT_W - 1;

    logic             we_ctl, we_tim0, we_tim1, we_stat, we_cmdq;
    logic             run_rise, run_abort, done_evt;
    logic             ld_filling, ld_waiting;
    logic [EVT_W-1:0] set_vec, stat_q;

    // Write decode by offset.
    always_comb begin
        we_ctl  = reg_wr && (reg_addr == ADDR_W'(OFS_CTL));
        we_tim0 = reg_wr && (reg_addr == ADDR_W'(OFS_TIM0));
        we_tim1 = reg_wr && (reg_addr == ADDR_W'(OFS_TIM1));
        we_stat = reg_wr && (reg_addr == ADDR_W'(OFS_STAT));
        we_cmdq = reg_wr && (reg_addr == ADDR_W'(OFS_CMDQ));
    end

    // Event assembly onto the status bit positions.
    always_comb begin
        set_vec            = '0;
        set_vec[ST_CMDREQ] = run_rise;
        set_vec[ST_RDREQ]  = ev_rd_req;
        set_vec[ST_WRREQ]  = ev_wr_req;
        set_vec[ST_SBE]    = ev_sbe;
        set_vec[ST_DBE]    = ev_dbe;
        set_vec[ST_DONE]   = done_evt;
        set_vec[ST_FRDY]   = ev_flash_rdy;
    end

    nfc_cfg_regs #(.W(REG_W)) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_ctl    (we_ctl),
        .we_tim0   (we_tim0),
        .we_tim1   (we_tim1),
        .wdata     (reg_wdata),
        .run_clr   (done_evt),
        .ctl_q     (ctl_cfg),
        .tim0_q    (tim0_cfg),
        .tim1_q    (tim1_cfg),
        .run_rise  (run_rise),
        .run_abort (run_abort)
    );

    nfc_cmd_loader #(.W(REG_W), .WORDS(CMD_WORDS)) i_loader (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (run_rise),
        .abort     (run_abort),
        .push      (we_cmdq),
        .wdata     (reg_wdata),
        .seq_done  (seq_done),
        .cmd_valid (cmd_valid),
        .cmd_words (cmd_words),
        .done_evt  (done_evt),
        .filling   (ld_filling),
        .waiting   (ld_waiting)
    );

    nfc_stat_regs #(.N(EVT_W)) i_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .w1c_we   (we_stat),
        .w1c_bits (reg_wdata[EVT_W-1:0]),
        .set_vec  (set_vec),
        .mask     (ctl_cfg[EVT_W-1:0]),
        .stat_q   (stat_q),
        .irq      (irq)
    );

    // Read multiplexer; unmapped offsets read zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFS_CTL))       reg_rdata = ctl_cfg;
        else if (reg_addr == ADDR_W'(OFS_TIM0)) reg_rdata = tim0_cfg;
        else if (reg_addr == ADDR_W'(OFS_TIM1)) reg_rdata = tim1_cfg;
        else if (reg_addr == ADDR_W'(OFS_STAT)) reg_rdata = {{STAT_PAD{1'b0}}, flash_rdy_lvl, stat_q};
    end

endmodule

// File: rtl/nfc_regfront_chk.sv
// nfc_regfront_chk: temporal properties of the front-end, bound to the top.
// Assumes the bound signals are the top's own status, loader and decode nets.
module nfc_regfront_chk
    import nfc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic             run,
    input logic [EVT_W-1:0] stat_q,
    input logic             irq,
    input logic             filling,
    input logic             waiting,
    input logic             seq_done,
    input logic             ctl_we,
    input logic             cmdq_we
);

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |=> !cmd_valid); // R4
    AST_VALID_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |-> (run && waiting)); // R4
    AST_RUN_RISE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n) $rose(run) |-> stat_q[ST_CMDREQ]); // R3
    AST_UNARMED_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n) (cmdq_we && !filling) |=> !cmd_valid); // R5
    AST_DONE_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n) (waiting && seq_done && !ctl_we) |=> (!run && stat_q[ST_DONE])); // R6
    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n) !(|stat_q) |=> !irq); // R10
    AST_UNUSED_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (stat_q[7:5] == 3'b000) && (stat_q[10:9] == 2'b00)); // R9

endmodule

bind nfc_regfront nfc_regfront_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .run       (ctl_cfg[28]),
    .stat_q    (stat_q),
    .irq       (irq),
    .filling   (ld_filling),
    .waiting   (ld_waiting),
    .seq_done  (seq_done),
    .ctl_we    (we_ctl),
    .cmdq_we   (we_cmdq)
);

// File: tb/test_nfc_regfront.sv
module test_nfc_regfront;
    localparam int AW = 8;
    localparam logic [7:0] A_CTL = 8'h00, A_T0 = 8'h04, A_T1 = 8'h0C, A_ST = 8'h14, A_CQ = 8'h48;
    localparam logic [31:0] RUN = 32'h1000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_rd_req = 0, ev_wr_req = 0, ev_sbe = 0, ev_dbe = 0, ev_flash_rdy = 0;
    logic        flash_rdy_lvl = 0;
    logic        seq_done = 0;
    logic        cmd_valid;
    logic [95:0] cmd_words;
    logic [31:0] ctl_cfg, tim0_cfg, tim1_cfg;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    nfc_regfront #(.ADDR_W(AW), .CMD_WORDS(3)) i_nfc_regfront (.*);

    task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic ev_pulse(input logic [4:0] v);
        @(negedge clk);
        {ev_flash_rdy, ev_dbe, ev_sbe, ev_wr_req, ev_rd_req} = v;
        @(negedge clk);
        {ev_flash_rdy, ev_dbe, ev_sbe, ev_wr_req, ev_rd_req} = 5'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        seq_done = 1'b1;
        @(negedge clk);
        seq_done = 1'b0;
    endtask

    function automatic logic [11:0] ev_map(input logic [4:0] v);
        logic [11:0] s = '0;
        s[1] = v[0]; s[2] = v[1]; s[3] = v[2]; s[4] = v[3]; s[11] = v[4];
        return s;
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [31:0] d;
        logic [31:0] w [3];
        logic [11:0] masks [3];
        masks[0] = 12'h000; masks[1] = 12'hFFF; masks[2] = 12'h7E7;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTL, d); chk("R1 ctl", d, 0);
        rd(A_T0, d);  chk("R1 tim0", d, 0);
        rd(A_T1, d);  chk("R1 tim1", d, 0);
        rd(A_ST, d);  chk("R1 status", d, 0);
        chk("R1 irq/valid", {irq, cmd_valid}, 0);
        chk("R1 words", cmd_words, 0);

        // R2 map and read-back
        wr(A_T0, 32'hA5A5_1234); wr(A_T1, 32'h0F0F_8001);
        rd(A_T0, d); chk("R2 tim0 read", d, 32'hA5A5_1234);
        rd(A_T1, d); chk("R2 tim1 read", d, 32'h0F0F_8001);
        chk("R2 tim outputs", {tim0_cfg, tim1_cfg}, {32'hA5A5_1234, 32'h0F0F_8001});
        wr(8'h30, 32'hFFFF_FFFF);
        rd(8'h30, d); chk("R2 unmapped read", d, 0);
        rd(8'h40, d); chk("R2 data offset read", d, 0);
        rd(A_CTL, d); chk("R2 unmapped write ignored", d, 0);

        // R5 command write before run is ignored
        wr(A_CQ, 32'hDEAD_BEEF);
        chk("R5 pre-run words", cmd_words, 0);
        chk("R5 pre-run valid", cmd_valid, 0);
        rd(A_ST, d); chk("R5 pre-run status", d, 0);

        // R6 done while idle is ignored
        done_pulse();
        rd(A_ST, d); chk("R6 idle done ignored", d, 0);

        // R3 R4 R5 R6 command sequences with varied words
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 3; k++) w[k] = 32'h1000_0000 * (k + 1) + 32'h0001_0203 * (c + 1) + k;
            wr(A_CTL, RUN | 32'h0000_0FFF);
            rd(A_ST, d); chk("R3 request bit", d[0], 1);
            rd(A_CTL, d); chk("R3 run set", d[28], 1);
            wr(A_ST, 32'hFFF);
            wr(A_CQ, w[0]); chk("R4 no valid after word0", cmd_valid, 0);
            wr(A_CQ, w[1]); chk("R4 no valid after word1", cmd_valid, 0);
            wr(A_CQ, w[2]);
            chk("R4 valid pulse", cmd_valid, 1);
            chk("R4 word order", cmd_words, {w[2], w[1], w[0]});
            @(negedge clk); chk("R4 valid one cycle", cmd_valid, 0);
            wr(A_CQ, 32'h1234_5678);
            chk("R5 fourth write words", cmd_words, {w[2], w[1], w[0]});
            chk("R5 fourth write valid", cmd_valid, 0);
            rd(A_ST, d); chk("R6 no done before pulse", d[8], 0);
            done_pulse();
            rd(A_ST, d); chk("R6 done bit", d, 32'h100);
            rd(A_CTL, d); chk("R6 run cleared", d, 32'h0000_0FFF);
            wr(A_ST, 32'hFFF);
        end

        // R7 abort while filling, then restart at word 0
        wr(A_CTL, RUN | 32'hFFF);
        wr(A_CQ, 32'hBAD0_0001);
        wr(A_CTL, 32'hFFF);
        rd(A_CTL, d); chk("R7 abort clears run", d[28], 0);
        done_pulse();
        rd(A_ST, d); chk("R7 no done after abort", d[8], 0);
        wr(A_ST, 32'hFFF);
        wr(A_CTL, RUN | 32'hFFF);
        wr(A_CQ, 32'hAAAA_0000); wr(A_CQ, 32'hBBBB_1111); wr(A_CQ, 32'hCCCC_2222);
        chk("R7 restart valid", cmd_valid, 1);
        chk("R7 restart word order", cmd_words, {32'hCCCC_2222, 32'hBBBB_1111, 32'hAAAA_0000});
        // R7 abort while waiting: later done ignored
        wr(A_CTL, 32'hFFF);
        done_pulse();
        rd(A_ST, d); chk("R7 abort in wait no done", d[8], 0);
        wr(A_ST, 32'hFFF);

        // R8 set wins over clear on the same edge
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = A_ST; reg_wdata = 32'hFFF; ev_sbe = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; ev_sbe = 1'b0;
        rd(A_ST, d); chk("R8 set wins", d, 32'h008);
        wr(A_ST, 32'hFFF);

        // R8 R9 R10 sweep: all event combinations against three masks
        for (int v = 0; v < 32; v++) begin
            for (int m = 0; m < 3; m++) begin
                logic [11:0] es;
                es = ev_map(5'(v));
                flash_rdy_lvl = v[0] ^ m[0];
                wr(A_CTL, {20'h0, masks[m]});
                wr(A_ST, 32'hFFF);
                ev_pulse(5'(v));
                rd(A_ST, d);
                chk("R9 status bits", d, {19'h0, flash_rdy_lvl, es});
                @(negedge clk);
                chk("R10 irq", irq, |(es & ~masks[m]));
                wr(A_ST, 32'h00E);
                rd(A_ST, d);
                chk("R8 partial clear", d[11:0], es & ~12'h00E);
                @(negedge clk);
                chk("R10 irq after clear", irq, |(es & ~12'h00E & ~masks[m]));
            end
        end
        wr(A_ST, 32'hFFF);
        rd(A_ST, d); chk("R8 full clear", d[11:0], 0);

        summary();
    end
endmodule